// File: doc/BRIEF.md
# A/B Ping-Pong Buffer Ownership Controller

This block runs the two-buffer handoff for one direction of a DMA channel. It holds two buffer slots, A and B. Each slot has a start address, a byte length and one ownership bit. The bit says who may touch the slot: the host (0) or the controller (1). The host programs a slot only while it owns it, and the same write hands the slot to the controller. The controller works through the slots strictly in turn, A then B then A. It transfers one byte per acknowledged request. When a slot is finished, the controller hands it back to the host and raises a one-cycle completion pulse. The pulse names the slot and carries the byte count.

The same logic serves either direction. On transmit, each byte step reads from the buffer. On receive, each byte step writes into it. The bus-master protocol and the data FIFO stay outside. They see only a request, an address and a per-byte acknowledge. The channel-level enable pauses the engine without losing its place. If the slot due next still belongs to the host, the engine waits for it and never skips to the other slot.

Top module: `dbuf_own_ctrl`

## Requirements
- R1: After reset, both ownership bits read 0 (host-owned), the current slot is A (`xfer_buf`=0), and `xfer_req`, `done_pulse` and `cfg_err` are 0.
- R2: A host write (`cfg_we`=1) to a host-owned slot with a nonzero length stores the address and the length. On the next cycle, that slot's ownership bit reads 1.
- R3: A host write is ignored when it targets a controller-owned slot or has a length of 0. Ignored writes raise `cfg_err` for exactly one cycle and leave the slot's address, length and ownership unchanged.
- R4: `xfer_req` is 1 only while `dma_en` is 1 and the current slot is controller-owned. While it is 1, `xfer_addr` equals the slot's start address plus the bytes already transferred from that slot.
- R5: The acknowledge that brings the byte count to the programmed length completes the slot. On the next cycle, the slot's ownership bit reads 0 and `done_pulse` is 1 for one cycle. In that cycle, `done_buf` names the slot (0=A, 1=B) and `done_cnt` equals the length.
- R6: After a completion, the current slot switches to the other slot. If that slot is host-owned, `xfer_req` stays 0, even when the slot just finished has been handed back to the controller.
- R7: While `dma_en` is 0, progress holds. When it returns to 1, transfer resumes at the same address.
- R8: `xfer_ack` has no effect while `xfer_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe for a slot |
| cfg_sel | input | 1 | Slot written: 0=A, 1=B |
| cfg_addr | input | ADDR_W | Start address for the slot |
| cfg_len | input | LEN_W | Byte length for the slot (nonzero) |
| dma_en | input | 1 | Channel enable for the engine |
| xfer_ack | input | 1 | One byte transferred at `xfer_addr` |
| own_a | output | 1 | Slot A owner: 1=controller |
| own_b | output | 1 | Slot B owner: 1=controller |
| cfg_err | output | 1 | One-cycle pulse for a rejected write |
| xfer_req | output | 1 | Engine requests a byte transfer |
| xfer_buf | output | 1 | Current slot: 0=A, 1=B |
| xfer_addr | output | ADDR_W | Address of the next byte |
| done_pulse | output | 1 | One-cycle slot completion pulse |
| done_buf | output | 1 | Slot that completed |
| done_cnt | output | LEN_W | Bytes transferred in the completed slot |

## Verification
A wrong ownership bit shows on `own_a`/`own_b` one cycle after the write or completion that should have set it. It also shows on `xfer_req`, which either rises for a slot the host still holds or stays low for one handed over. A slot pointer that fails to alternate appears right after the completion pulse, as `xfer_buf` and `xfer_addr` pointing at the wrong slot. A miscounted byte offset shows on `xfer_addr` at the very next acknowledge. It also shows as an early or late `done_pulse`, with a `done_cnt` that differs from the programmed length.

// File: rtl/dbuf_own_ctrl.sv
module dbuf_own_ctrl #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              dma_en,
  input  logic              xfer_ack,
  output logic              own_a,
  output logic              own_b,
  output logic              cfg_err,
  output logic              xfer_req,
  output logic              xfer_buf,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              done_pulse,
  output logic              done_buf,
  output logic [LEN_W-1:0]  done_cnt
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [1:0]        own_q;
  logic [ADDR_W-1:0] base_q [2];
  logic [LEN_W-1:0]  len_q  [2];
  logic              cur_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  cnt_nx;
  logic              cfg_ok, fire, last;

  assign cfg_ok    = cfg_we && !own_q[cfg_sel] && (cfg_len != '0);
  assign xfer_req  = dma_en && own_q[cur_q];
  assign fire      = xfer_req && xfer_ack;
  assign cnt_nx    = cnt_q + ONE;
  assign last      = (cnt_nx == len_q[cur_q]);
  assign xfer_buf  = cur_q;
  assign xfer_addr = base_q[cur_q] + ADDR_W'(cnt_q);
  assign own_a     = own_q[0];
  assign own_b     = own_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q      <= '0;
      cur_q      <= 1'b0;
      cnt_q      <= '0;
      cfg_err    <= 1'b0;
      done_pulse <= 1'b0;
      done_buf   <= 1'b0;
      done_cnt   <= '0;
      for (int i = 0; i < 2; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      done_pulse <= 1'b0;
      cfg_err    <= cfg_we && !cfg_ok;
      if (cfg_ok) begin
        base_q[cfg_sel] <= cfg_addr;
        len_q[cfg_sel]  <= cfg_len;
        own_q[cfg_sel]  <= 1'b1;
      end
      if (fire) begin
        if (last) begin
          own_q[cur_q] <= 1'b0;
          cur_q        <= ~cur_q;
          cnt_q        <= '0;
          done_pulse   <= 1'b1;
          done_buf     <= cur_q;
          done_cnt     <= cnt_nx;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  // R5: a completed slot is back with the host when the pulse appears
  a_r5_done_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !own_q[done_buf]);

  // R5: the reported count equals the programmed length of that slot
  a_r5_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done_cnt == len_q[done_buf]);

  // R6: completion moves the pointer to the other slot
  a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> xfer_buf != done_buf);

  // R3: a rejected write leaves stored lengths untouched
  a_r3_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(len_q[0]) && $stable(len_q[1]) && $stable(base_q[0]) && $stable(base_q[1]));

  // R8: no request means no progress
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_req |=> $stable(cnt_q) && $stable(cur_q));

  // R4: the byte offset never reaches the programmed length while requesting
  a_r4_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> cnt_q < len_q[cur_q]);
endmodule

// File: tb/tb_dbuf_own_ctrl.sv
module tb_dbuf_own_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0, dma_en = 0, xfer_ack = 0;
  logic [15:0] cfg_addr = '0;
  logic [11:0] cfg_len = '0;
  logic own_a, own_b, cfg_err, xfer_req, xfer_buf, done_pulse, done_buf;
  logic [15:0] xfer_addr;
  logic [11:0] done_cnt;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dbuf_own_ctrl dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_addr, .cfg_len, .dma_en,
    .xfer_ack, .own_a, .own_b, .cfg_err, .xfer_req, .xfer_buf, .xfer_addr,
    .done_pulse, .done_buf, .done_cnt);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic give(input logic sel, input logic [15:0] a, input logic [11:0] l);
    cfg_we = 1; cfg_sel = sel; cfg_addr = a; cfg_len = l;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ack1();
    xfer_ack = 1;
    @(negedge clk);
    xfer_ack = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 own_a", own_a, 0);
    chk("R1 own_b", own_b, 0);
    chk("R1 xfer_buf", xfer_buf, 0);
    chk("R1 xfer_req", xfer_req, 0);
    chk("R1 done_pulse", done_pulse, 0);
    chk("R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_drain_a();
    give(0, 16'h0100, 12'd3);
    chk("R2 own_a set", own_a, 1);
    chk("R4 no req when disabled", xfer_req, 0);
    dma_en = 1;
    #0;
    chk("R4 req", xfer_req, 1);
    chk("R4 addr0", xfer_addr, 16'h0100);
    ack1();
    chk("R4 addr1", xfer_addr, 16'h0101);
    chk("R5 no early done", done_pulse, 0);
    ack1();
    chk("R4 addr2", xfer_addr, 16'h0102);
    ack1();
    chk("R5 done", done_pulse, 1);
    chk("R5 done_buf", done_buf, 0);
    chk("R5 done_cnt", done_cnt, 3);
    chk("R5 own_a cleared", own_a, 0);
    chk("R6 now B", xfer_buf, 1);
    chk("R6 stall B host", xfer_req, 0);
    @(negedge clk);
    chk("R5 pulse single", done_pulse, 0);
  endtask

  task automatic t_stall_alternate();
    give(0, 16'h0300, 12'd1);
    chk("R6 no skip to A", xfer_req, 0);
    chk("R6 still B", xfer_buf, 1);
    give(1, 16'h0200, 12'd2);
    chk("R2 own_b set", own_b, 1);
    chk("R6 req B", xfer_req, 1);
    chk("R6 addr B", xfer_addr, 16'h0200);
    ack1();
    chk("R4 addr B1", xfer_addr, 16'h0201);
    ack1();
    chk("R5 done B", done_pulse, 1);
    chk("R5 done_buf B", done_buf, 1);
    chk("R5 cnt B", done_cnt, 2);
    chk("R6 back to A", xfer_buf, 0);
    chk("R6 A addr", xfer_addr, 16'h0300);
    chk("R6 A req", xfer_req, 1);
    ack1();
    chk("R5 done A len1", done_pulse, 1);
    chk("R5 cnt A len1", done_cnt, 1);
  endtask

  task automatic t_errors();
    give(1, 16'h0400, 12'd4);
    chk("R2 B taken", own_b, 1);
    give(1, 16'h0999, 12'd9);
    chk("R3 err owned", cfg_err, 1);
    chk("R3 addr kept", xfer_addr, 16'h0400);
    @(negedge clk);
    chk("R3 err single", cfg_err, 0);
    give(0, 16'h0500, 12'd0);
    chk("R3 err len0", cfg_err, 1);
    chk("R3 own_a unchanged", own_a, 0);
  endtask

  task automatic t_pause();
    ack1();
    chk("R7 addr after one", xfer_addr, 16'h0401);
    dma_en = 0;
    #0;
    chk("R7 req low", xfer_req, 0);
    ack1();
    ack1();
    chk("R8 ack ignored", xfer_addr, 16'h0401);
    chk("R8 no done", done_pulse, 0);
    dma_en = 1;
    #0;
    chk("R7 resume addr", xfer_addr, 16'h0401);
    repeat (3) ack1();
    chk("R7 done after resume", done_pulse, 1);
    chk("R7 cnt", done_cnt, 4);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_drain_a();
    t_stall_alternate();
    t_errors();
    t_pause();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule